// File: doc/BRIEF.md
# Interrupt Acknowledge Responder

This block is the interrupter side of a bus interrupt acknowledge. Once a one-cycle `irq_set` pulse arrives, it holds a request and pulls low the active-low request line that matches its configured priority level (1 to 7). It then watches the address strobe, the acknowledge qualifier, the 3-bit level code on the low address lines and the first data strobe. It waits for an acknowledge cycle aimed at its own level and answers it with an 8-bit status/ID byte. The answer uses a fully interlocked transfer-acknowledge handshake.

All bus inputs are assumed to be synchronized to `clk` already. The data bus is modelled as a value `data_out` with a separate enable `data_oe`. The strict order of events is fixed:
- The data strobe falls.
- The byte is driven.
- After `DTACK_DLY` cycles, the acknowledge falls.
- The strobe rises.
- The byte is released.
- The acknowledge rises.

Passing the acknowledge along a daisy chain and the electrical drivers are outside this block. The status byte is a plain configuration input, and no stream interface is involved, so no back-pressure rules apply.

Top module: `iar_responder`

## Requirements
- R1: While `rst_n` is low, and after reset until a request is set, every bit of `irq_n` is 1, `dtack_n` is 1, `data_oe` is 0 and `data_out` is 0.
- R2: A pulse on `irq_set` sets the pending request from the next cycle. While the request is pending, `irq_n[L-1]` is 0 for configured level L (`level_cfg` 1..7) and all other bits are 1. A `level_cfg` of 0 drives no line.
- R3: The block starts a response only when all of the following hold: `as_n` is 0, `iack_n` is 0, `addr_lvl` equals `level_cfg`, and a request is pending. A wrong level, `iack_n` high, or no pending request leaves `data_oe` at 0 and `dtack_n` at 1.
- R4: `data_oe` rises only on the clock edge after `ds0_n` has been sampled low in a matched cycle. It never rises earlier.
- R5: `dtack_n` falls exactly `DTACK_DLY` (≥1) cycles after `data_oe` rises. At that moment `data_out` equals the `status_id` captured when driving began.
- R6: While `ds0_n` stays low, `dtack_n` stays low and `data_oe` stays high.
- R7: On the edge after `ds0_n` is sampled high, `data_oe` falls while `dtack_n` stays low. `dtack_n` rises one cycle later.
- R8: The pending request, and with it the `irq_n` line, clears on the edge where the acknowledge completes. A later `irq_set` sets it again.
- R9: After a response, no new response starts until `as_n` has been sampled high. This holds even if the strobe falls again and a new request is pending.
- R10: If `as_n` rises before the data strobe falls, the cycle is abandoned and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_cfg | input | 3 | Configured priority level, 1..7 |
| status_id | input | 8 | Status/ID byte returned on acknowledge |
| irq_set | input | 1 | One-cycle pulse that raises a request |
| as_n | input | 1 | Address strobe, active low |
| iack_n | input | 1 | Acknowledge-cycle qualifier, active low |
| addr_lvl | input | 3 | Level code from the low address lines |
| ds0_n | input | 1 | First data strobe, active low |
| irq_n | output | 7 | Request lines, bit L-1 for level L, active low |
| data_out | output | 8 | Status/ID byte value |
| data_oe | output | 1 | Data bus drive enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench first presents near-miss acknowledge cycles: one with the wrong level and one with the qualifier high. A decoder that ignored either of these would drive the bus for another interrupter. It then holds the data strobe high for several cycles after the address strobe falls and times the drive enable against the acknowledge. A design that drove early, or acknowledged before the byte was stable, shows up as a wrong cycle count in the scoreboard. It also lets the strobe fall a second time while the address strobe is held low, and raises the address strobe before the data strobe. A responder without proper re-arming would answer twice in one bus cycle, and one that cleared its request on an abandoned cycle would lose the interrupt.

// File: rtl/iar_pkg.sv
package iar_pkg;
  localparam int unsigned NUM_LEVELS = 7;
  localparam int unsigned LVL_W      = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DS,
    ST_DRIVE,
    ST_DTACK,
    ST_RELEASE,
    ST_WAIT_AS
  } ack_state_e;
endpackage

// File: rtl/iar_request.sv
module iar_request (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_set,
  input  logic ack_done,
  output logic req_pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)        req_pending <= 1'b0;
    else if (irq_set)  req_pending <= 1'b1;
    else if (ack_done) req_pending <= 1'b0;
  end

  AST_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && !irq_set) |=> !req_pending); // R8
  AST_SET_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> req_pending); // R2
endmodule

// File: rtl/iar_decode.sv
module iar_decode #(
  parameter int unsigned LVL_W = 3
) (
  input  logic [LVL_W-1:0] level_cfg,
  input  logic [LVL_W-1:0] addr_lvl,
  input  logic             as_n,
  input  logic             iack_n,
  input  logic             req_pending,
  output logic             hit
);
  logic lvl_ok;
  assign lvl_ok = (level_cfg != '0) && (addr_lvl == level_cfg);
  assign hit    = !as_n && !iack_n && lvl_ok && req_pending;
endmodule

// File: rtl/iar_handshake.sv
module iar_handshake
  import iar_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DTACK_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              as_n,
  input  logic              ds0_n,
  input  logic [DATA_W-1:0] status_id,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              dtack_n,
  output logic              ack_done
);
  localparam int unsigned CNT_W = $clog2(DTACK_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DTACK_DLY - 1);

  ack_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] byte_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (hit) state_d = ST_WAIT_DS;
      ST_WAIT_DS: begin
        if (as_n)        state_d = ST_IDLE;
        else if (!ds0_n) state_d = ST_DRIVE;
      end
      ST_DRIVE:   if (cnt_q == CNT_LAST) state_d = ST_DTACK;
      ST_DTACK:   if (ds0_n) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_WAIT_AS;
      ST_WAIT_AS: if (as_n) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DRIVE) cnt_q <= cnt_q + 1'b1;
      else                     cnt_q <= '0;
      if (state_q == ST_WAIT_DS && state_d == ST_DRIVE) byte_q <= status_id;
      else if (state_d == ST_RELEASE)                   byte_q <= '0;
    end
  end

  assign data_oe  = (state_q == ST_DRIVE) || (state_q == ST_DTACK);
  assign dtack_n  = !((state_q == ST_DTACK) || (state_q == ST_RELEASE));
  assign data_out = data_oe ? byte_q : '0;
  assign ack_done = (state_q == ST_DTACK) && ds0_n;

  initial begin
    AST_DLY_MIN: assert (DTACK_DLY >= 1); // R5
  end

  AST_OE_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(!ds0_n)); // R4
  AST_DTACK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> (data_oe && $past(data_oe))); // R5
  AST_DTACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && data_oe && !ds0_n) |=> (!dtack_n && data_oe)); // R6
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_n) |-> (!data_oe && $past(!data_oe))); // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_AS && !as_n) |=> (!data_oe && dtack_n)); // R9
endmodule

// File: rtl/iar_responder.sv
module iar_responder
  import iar_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DTACK_DLY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      level_cfg,
  input  logic [DATA_W-1:0]     status_id,
  input  logic                  irq_set,
  input  logic                  as_n,
  input  logic                  iack_n,
  input  logic [LVL_W-1:0]      addr_lvl,
  input  logic                  ds0_n,
  output logic [NUM_LEVELS-1:0] irq_n,
  output logic [DATA_W-1:0]     data_out,
  output logic                  data_oe,
  output logic                  dtack_n
);
  logic req_pending, hit, ack_done;

  iar_request u_req (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set),
    .ack_done(ack_done), .req_pending(req_pending)
  );

  iar_decode #(.LVL_W(LVL_W)) u_dec (
    .level_cfg(level_cfg), .addr_lvl(addr_lvl), .as_n(as_n),
    .iack_n(iack_n), .req_pending(req_pending), .hit(hit)
  );

  iar_handshake #(.DATA_W(DATA_W), .DTACK_DLY(DTACK_DLY)) u_hs (
    .clk(clk), .rst_n(rst_n), .hit(hit), .as_n(as_n), .ds0_n(ds0_n),
    .status_id(status_id), .data_out(data_out), .data_oe(data_oe),
    .dtack_n(dtack_n), .ack_done(ack_done)
  );

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_line
    assign irq_n[i] = !(req_pending && (level_cfg == LVL_W'(i + 1)));
  end

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n)); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_n && dtack_n && !data_oe) |=> !data_oe); // R3
endmodule

// File: tb/tb_iar_responder.sv
`timescale 1ns/1ps
module tb_iar_responder;
  localparam int DLY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] level_cfg = 3'd3;
  logic [7:0] status_id = 8'h00;
  logic       irq_set = 1'b0;
  logic       as_n = 1'b1, iack_n = 1'b1, ds0_n = 1'b1;
  logic [2:0] addr_lvl = 3'd0;
  logic [6:0] irq_n;
  logic [7:0] data_out;
  logic       data_oe, dtack_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int oe_cnt = 0;
  logic prev_dtack = 1'b1;
  bit done = 0;

  always #2.5 clk = ~clk;

  iar_responder #(.DATA_W(8), .DTACK_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .level_cfg(level_cfg), .status_id(status_id),
    .irq_set(irq_set), .as_n(as_n), .iack_n(iack_n), .addr_lvl(addr_lvl),
    .ds0_n(ds0_n), .irq_n(irq_n), .data_out(data_out), .data_oe(data_oe),
    .dtack_n(dtack_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard on each acknowledge fall
  always @(negedge clk) begin
    if (rst_n) begin
      if (!dtack_n && prev_dtack) begin
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected acknowledge", 1, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(data_out == e, "R5 status byte", data_out, e);
          check(oe_cnt == DLY, "R5 data-to-ack cycles", oe_cnt, DLY);
          check(data_oe == 1'b1, "R5 data driven at ack", data_oe, 1);
        end
      end
      if (data_oe && dtack_n) oe_cnt++;
      else if (!data_oe) oe_cnt = 0;
      prev_dtack = dtack_n;
    end
  end

  task automatic pulse_set();
    @(negedge clk) irq_set = 1'b1;
    @(negedge clk) irq_set = 1'b0;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    as_n = 1'b1; iack_n = 1'b1; ds0_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // full matched acknowledge
  task automatic ack_ok(input logic [7:0] sid, input bool_keep_as);
    status_id = sid;
    @(negedge clk);
    as_n = 1'b0; iack_n = 1'b0; addr_lvl = level_cfg;
    repeat (3) @(negedge clk);
    check(data_oe == 1'b0, "R4 no drive before strobe", data_oe, 0);
    exp_q.push_back(sid);
    ds0_n = 1'b0;
    for (int i = 0; i < 20 && dtack_n; i++) @(negedge clk);
    check(dtack_n == 1'b0, "R5 acknowledge arrives", dtack_n, 0);
    repeat (3) @(negedge clk);
    check(!dtack_n && data_oe, "R6 held while strobe low", {dtack_n, data_oe}, 2'b01);
    ds0_n = 1'b1;
    @(negedge clk);
    check(data_oe == 1'b0 && dtack_n == 1'b0, "R7 data released first", {dtack_n, data_oe}, 2'b00);
    @(negedge clk);
    check(dtack_n == 1'b1, "R7 ack released after", dtack_n, 1);
    check(irq_n == 7'h7f, "R8 request cleared", irq_n, 7'h7f);
    if (!bool_keep_as) bus_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_n == 7'h7f && dtack_n && !data_oe && data_out == 0, "R1 reset state",
          {irq_n, dtack_n, data_oe}, {7'h7f, 2'b10});
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_n == 7'h7f && dtack_n && !data_oe, "R1 after reset", irq_n, 7'h7f);

    // R3: no pending request, matched cycle
    @(negedge clk); as_n = 0; iack_n = 0; addr_lvl = 3'd3; ds0_n = 0;
    repeat (6) @(negedge clk);
    check(dtack_n && !data_oe, "R3 no request no response", {dtack_n, data_oe}, 2'b10);
    bus_idle();

    pulse_set();
    check(irq_n == ~7'b0000100, "R2 level 3 line", irq_n, ~7'b0000100);

    // R3 wrong level
    @(negedge clk); as_n = 0; iack_n = 0; addr_lvl = 3'd5; ds0_n = 0;
    repeat (6) @(negedge clk);
    check(dtack_n && !data_oe, "R3 wrong level ignored", {dtack_n, data_oe}, 2'b10);
    bus_idle();
    // R3 qualifier high
    @(negedge clk); as_n = 0; iack_n = 1; addr_lvl = 3'd3; ds0_n = 0;
    repeat (6) @(negedge clk);
    check(dtack_n && !data_oe, "R3 qualifier high ignored", {dtack_n, data_oe}, 2'b10);
    check(irq_n == ~7'b0000100, "R3 request kept", irq_n, ~7'b0000100);
    bus_idle();

    ack_ok(8'hA5, 1'b0);

    // R8 new request, R9 no second response inside one strobe
    pulse_set();
    check(irq_n == ~7'b0000100, "R8 request set again", irq_n, ~7'b0000100);
    ack_ok(8'h3C, 1'b1);
    pulse_set();
    ds0_n = 1'b0;
    repeat (6) @(negedge clk);
    check(dtack_n && !data_oe, "R9 no re-response before strobe high", {dtack_n, data_oe}, 2'b10);
    bus_idle();
    ack_ok(8'h5E, 1'b0);

    // R10 abandoned cycle keeps request
    pulse_set();
    @(negedge clk); as_n = 0; iack_n = 0; addr_lvl = 3'd3;
    repeat (2) @(negedge clk);
    as_n = 1'b1; iack_n = 1'b1;
    repeat (2) @(negedge clk);
    check(irq_n == ~7'b0000100 && !data_oe, "R10 request kept after abort", irq_n, ~7'b0000100);
    ack_ok(8'h11, 1'b0);

    // other levels
    level_cfg = 3'd7; pulse_set();
    check(irq_n == ~7'b1000000, "R2 level 7 line", irq_n, ~7'b1000000);
    ack_ok(8'hF0, 1'b0);
    level_cfg = 3'd1; pulse_set();
    check(irq_n == ~7'b0000001, "R2 level 1 line", irq_n, ~7'b0000001);
    ack_ok(8'h0F, 1'b0);
    level_cfg = 3'd0; pulse_set();
    check(irq_n == 7'h7f, "R2 level 0 drives none", irq_n, 7'h7f);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule